// File: doc/BRIEF.md
# UART Receive Path with Single-Entry Hold Buffer

This block is the receive half of an asynchronous serial port. It watches a serial input line, synchronises it, and uses an external 16x oversampling tick to find a start bit and confirm it. It then shifts in eight data bits, an optional parity bit and one or two stop bits. When the last stop bit has been sampled, the byte is placed in a one-entry hold buffer. The block then raises a full flag and a one-cycle interrupt pulse. A host takes the byte through a read strobe, and that strobe empties the buffer.

If a second frame completes while the buffer still holds an unread byte, the new byte is thrown away and the stored byte is left untouched. An overrun flag records that this happened. Parity and framing errors are flagged next to the stored byte, and the byte is stored in either case.

The frame state machine uses five states. In ST_IDLE it waits for a low line. ST_START follows the falling edge and confirms the start bit at mid-bit; from there it goes to ST_DATA if the line is low, or back to ST_IDLE if it is high. ST_DATA takes eight mid-bit samples. After the last data bit it moves to ST_PARITY when parity is on, or to ST_STOP when it is off. ST_PARITY takes one sample and moves to ST_STOP. ST_STOP takes one or two samples and then returns to ST_IDLE with a completion strobe. Dropping the enable forces ST_IDLE from any state.

Top module: `uart_rx_core`

## Requirements
- R1: While `rx_en` is 0 the receiver stays idle. A complete frame on `rxd` during that time stores nothing, does not set `buf_full` and raises no `rx_irq`.
- R2: A low line seen on a tick starts a frame. The line is re-sampled 8 ticks later. If it is high there, the receiver returns to idle and stores nothing, and a later valid frame is still received correctly.
- R3: Each data bit is sampled at mid-bit, 16 ticks after the previous sample. Eight bits are assembled with the first received bit as bit 0 of `rd_data`.
- R4: A frame is start, 8 data bits, a parity bit only when `parity_en` is 1, and one stop bit, or two when `stop_two` is 1. The byte is stored only after the last stop bit has been sampled.
- R5: Storing a byte sets `buf_full` and makes `rx_irq` high for exactly one clock cycle, in the same cycle in which `buf_full` first becomes 1.
- R6: When a frame completes while `buf_full` is 1 and there is no read in that cycle, the byte is discarded. `rd_data` and `buf_full` keep their values, `ovr_err` becomes 1 and no `rx_irq` is raised.
- R7: A one-cycle `rd_strobe` clears `buf_full`, `ovr_err`, `par_err` and `frm_err` on the next clock edge. If a frame completes in the same cycle as the read, the new byte is stored.
- R8: With `parity_en` set, `par_err` is 1 for the stored byte when the data bits and the parity bit together hold an odd count of ones (`parity_odd`=0) or an even count (`parity_odd`=1). The byte is stored anyway.
- R9: `frm_err` is 1 for the stored byte when any sampled stop bit is low. The byte is stored anyway.
- R10: After reset `buf_full`, `rx_irq`, `ovr_err`, `par_err` and `frm_err` are 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| os_tick | input | 1 | 16x oversampling tick, one cycle wide |
| rxd | input | 1 | Serial input line, idle high |
| parity_en | input | 1 | Expect a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_two | input | 1 | Expect two stop bits |
| rd_strobe | input | 1 | Host read of the hold buffer |
| rd_data | output | 8 | Stored byte |
| buf_full | output | 1 | Hold buffer holds an unread byte |
| rx_irq | output | 1 | One-cycle pulse when a byte is stored |
| ovr_err | output | 1 | A frame was dropped because the buffer was full |
| par_err | output | 1 | Parity error for the stored byte |
| frm_err | output | 1 | Framing error for the stored byte |

## Verification
The bench sends a second frame on top of an unread byte. A design that overwrites on overrun would show the second byte, and one that forgets to flag it would leave `ovr_err` low. A short low glitch checks start-bit confirmation: a receiver without the mid-bit check would store a byte made of idle ones. With two stop bits, the bench checks `buf_full` between the two stops, which catches a design that stores after the first stop. It also sends a low first stop, which catches a design that only looks at the last stop. It inverts the parity bit under both parities and sends a full frame while the receiver is disabled, to show that errors are flagged without losing the byte and that a disabled receiver stays silent.

// File: rtl/urx_pkg.sv
package urx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/urx_fsm.sv
module urx_fsm
    import urx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              tick,
    input  logic              rxd_s,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              stop_two,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);

    localparam int CNT_W  = $clog2(OVS);
    localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(DATA_W - 1);

    rx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  bit_q;
    logic              stop_idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              par_acc_q;
    logic              ferr_acc_q;

    logic at_mid, at_full, last_stop;

    assign at_mid    = tick && (cnt_q == MID_CNT);
    assign at_full   = tick && (cnt_q == FULL_CNT);
    assign last_stop = !stop_two || stop_idx_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick && !rxd_s) state_d = ST_START;
            ST_START:  if (at_mid) state_d = rxd_s ? ST_IDLE : ST_DATA;
            ST_DATA:   if (at_full && bit_q == LAST_BIT)
                           state_d = parity_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (at_full) state_d = ST_STOP;
            ST_STOP:   if (at_full && last_stop) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (!rx_en) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            bit_q      <= '0;
            stop_idx_q <= 1'b0;
            shift_q    <= '0;
            par_acc_q  <= 1'b0;
            ferr_acc_q <= 1'b0;
            done       <= 1'b0;
            data       <= '0;
            perr       <= 1'b0;
            ferr       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_d != state_q || at_full) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end

            unique case (state_q)
                ST_IDLE: begin
                    bit_q      <= '0;
                    stop_idx_q <= 1'b0;
                    par_acc_q  <= 1'b0;
                    ferr_acc_q <= 1'b0;
                end
                ST_START: ;
                ST_DATA: begin
                    if (at_full) begin
                        shift_q   <= {rxd_s, shift_q[DATA_W-1:1]};
                        par_acc_q <= par_acc_q ^ rxd_s;
                        bit_q     <= bit_q + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (at_full) par_acc_q <= par_acc_q ^ rxd_s;
                end
                ST_STOP: begin
                    if (at_full) begin
                        stop_idx_q <= 1'b1;
                        ferr_acc_q <= ferr_acc_q | !rxd_s;
                        if (last_stop && rx_en) begin
                            done <= 1'b1;
                            data <= shift_q;
                            perr <= parity_en && (par_acc_q ^ parity_odd);
                            ferr <= ferr_acc_q | !rxd_s;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/urx_holdbuf.sv
module urx_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] data_in,
    input  logic              perr_in,
    input  logic              ferr_in,
    input  logic              rd,
    output logic [DATA_W-1:0] data_out,
    output logic              full,
    output logic              irq,
    output logic              ovr,
    output logic              perr,
    output logic              ferr
);

    logic store;
    assign store = done && (!full || rd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out <= '0;
            full     <= 1'b0;
            irq      <= 1'b0;
            ovr      <= 1'b0;
            perr     <= 1'b0;
            ferr     <= 1'b0;
        end else begin
            irq <= store;
            if (store) begin
                data_out <= data_in;
                full     <= 1'b1;
                perr     <= perr_in;
                ferr     <= ferr_in;
            end else if (rd) begin
                full <= 1'b0;
                perr <= 1'b0;
                ferr <= 1'b0;
            end
            if (done && full && !rd) ovr <= 1'b1;
            else if (rd)             ovr <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              stop_two,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_full,
    output logic              rx_irq,
    output logic              ovr_err,
    output logic              par_err,
    output logic              frm_err
);

    logic              rxd_s;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    logic              frm_perr;
    logic              frm_ferr;

    urx_sync #(.STAGES(SYNC_N), .RESET_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxd_s)
    );

    urx_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .tick      (os_tick),
        .rxd_s     (rxd_s),
        .parity_en (parity_en),
        .parity_odd(parity_odd),
        .stop_two  (stop_two),
        .done      (frm_done),
        .data      (frm_data),
        .perr      (frm_perr),
        .ferr      (frm_ferr)
    );

    urx_holdbuf #(.DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (frm_done),
        .data_in (frm_data),
        .perr_in (frm_perr),
        .ferr_in (frm_ferr),
        .rd      (rd_strobe),
        .data_out(rd_data),
        .full    (buf_full),
        .irq     (rx_irq),
        .ovr     (ovr_err),
        .perr    (par_err),
        .ferr    (frm_err)
    );

endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              rd_strobe,
    input logic              frm_done,
    input logic [DATA_W-1:0] rd_data,
    input logic              buf_full,
    input logic              rx_irq,
    input logic              ovr_err
);

    // R1: a disabled receiver completes no frame
    p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !frm_done);

    // R5: interrupt only with a filled buffer
    p_irq_with_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> buf_full);

    // R5: interrupt lasts one cycle
    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    // R6: unread byte is never replaced
    p_keep_unread_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !rd_strobe) |=> $stable(rd_data) && buf_full);

    // R6: overrun only while full
    p_ovr_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> buf_full && !rx_irq);

    // R7: read without a completing frame empties the buffer
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !frm_done) |=> !buf_full && !ovr_err);

endmodule

bind uart_rx_core uart_rx_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .rd_strobe(rd_strobe),
    .frm_done (frm_done),
    .rd_data  (rd_data),
    .buf_full (buf_full),
    .rx_irq   (rx_irq),
    .ovr_err  (ovr_err)
);

// File: tb/sim_uart_rx_core.sv
`timescale 1ns/100ps
module sim_uart_rx_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       os_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       stop_two = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       buf_full, rx_irq, ovr_err, par_err, frm_err;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_core u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick), .rxd(rxd),
        .parity_en(parity_en), .parity_odd(parity_odd), .stop_two(stop_two),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .buf_full(buf_full),
        .rx_irq(rx_irq), .ovr_err(ovr_err), .par_err(par_err), .frm_err(frm_err)
    );

    always @(negedge clk) if (rx_irq) irq_cnt++;

    // {bad_stop, bad_par, stop_two, parity_odd, parity_en, data}
    localparam int NV = 7;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C},
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h81},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5A},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hF0},
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0F},
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h96}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic v);
        rxd = v;
        repeat (16) @(negedge clk);
    endtask

    // first stop is the one corrupted when bad_stop is set
    task automatic send_frame(input logic [7:0] d, input logic pe, input logic po,
                              input logic s2, input logic badp, input logic bads,
                              input logic chk_between);
        logic p;
        parity_en = pe; parity_odd = po; stop_two = s2;
        p = (^d) ^ po ^ badp;
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (pe) send_bit(p);
        send_bit(!bads);
        if (s2) begin
            rxd = 1'b1;
            repeat (4) @(negedge clk);
            if (chk_between) check("R4 no store before second stop", buf_full, 0);
            repeat (12) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic host_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    initial begin
        int irq_before;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 buf_full", buf_full, 0);
        check("R10 rx_irq", rx_irq, 0);
        check("R10 ovr_err", ovr_err, 0);
        check("R10 par_err", par_err, 0);
        check("R10 frm_err", frm_err, 0);
        check("R10 rd_data", rd_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 disabled receiver
        irq_before = irq_cnt;
        send_frame(8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1 no store while disabled", buf_full, 0);
        check("R1 no irq while disabled", irq_cnt, irq_before);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // vector table: R3 R4 R5 R8 R9 R7
        for (int v = 0; v < NV; v++) begin
            logic [12:0] e;
            e = VEC[v];
            irq_before = irq_cnt;
            send_frame(e[7:0], e[8], e[9], e[10], e[11], e[12], 1'b1);
            check("R3 data LSB first", rd_data, e[7:0]);
            check("R5 buf_full set", buf_full, 1);
            check("R5 one irq pulse", irq_cnt, irq_before + 1);
            check("R8 parity error", par_err, e[11] & e[8]);
            check("R9 framing error", frm_err, e[12]);
            host_read();
            check("R7 read clears full", buf_full, 0);
            check("R7 read clears errors", {par_err, frm_err}, 0);
        end

        // R2 false start
        parity_en = 1'b0; stop_two = 1'b0;
        irq_before = irq_cnt;
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        check("R2 glitch not stored", buf_full, 0);
        check("R2 glitch no irq", irq_cnt, irq_before);
        send_frame(8'h6E, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R2 frame after glitch", rd_data, 8'h6E);
        host_read();

        // R6 overrun keeps first byte
        irq_before = irq_cnt;
        send_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(8'h22, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R6 first byte kept", rd_data, 8'h11);
        check("R6 overrun flag", ovr_err, 1);
        check("R6 still full", buf_full, 1);
        check("R6 no irq on overrun", irq_cnt, irq_before + 1);
        check("R6 dropped frame leaves par_err", par_err, 0);
        host_read();
        check("R7 read clears overrun", ovr_err, 0);
        check("R7 read clears full after overrun", buf_full, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule